// File: doc/BRIEF.md
# Segmented Paging Address Translator

This block turns a 32-bit virtual address into a 30-bit physical address in two steps. The top bits of the address pick one of a small set of segment registers. Each register holds the byte address of that segment's page table and the number of entries in it. The middle bits are the virtual page number. The block checks it against the entry count and then uses it to index the table with a single memory read. The physical page number in the returned entry is placed above the untouched page offset. The block does not add the two.

Requests enter on a valid/ready stream and results leave on a valid/ready stream. Only one translation is in flight at a time, so `req_ready` stays low from acceptance until the result has been taken. A consumer may hold `rsp_ready` low for as long as it likes, and the result waits, unchanged, until it is taken. Segment registers are loaded through a plain write port while the block is idle. The page table read uses a one-cycle request pulse and a response that can come back after any number of cycles.

Top module: `segpage_xlate`

## Requirements
- R1: The virtual address is split as follows:
  - bits [31:29] are the segment index;
  - bits [28:12] are the virtual page number;
  - bits [11:0] are the page offset, which passes into the physical address unchanged.
- R2: A cycle with `seg_wr_en` high loads `seg_wr_base` and `seg_wr_bound` into the entry chosen by `seg_wr_idx`. After reset every entry has base 0 and bound 0.
- R3: A segment index of 6 or 7 (at or above the implemented count) completes with `rsp_code` = 1 and `rsp_paddr` = 0. No memory read is issued.
- R4: A virtual page number greater than or equal to the segment's bound completes with `rsp_code` = 2 and `rsp_paddr` = 0. No memory read is issued. A bound of 0 faults every page.
- R5: An in-range request raises `mem_req` for exactly one cycle with `mem_addr` = base + 4 × page number. It then waits for `mem_rvalid`, however many cycles that takes.
- R6: A returned entry with bit 31 clear completes with `rsp_code` = 3 and `rsp_paddr` = 0.
- R7: A returned entry with bit 31 set completes with `rsp_code` = 0 and `rsp_paddr` = {entry bits [17:0], offset}.
- R8: `req_ready` is high only when idle. `busy` is high from the cycle after acceptance until the result is taken.
- R9: While `rsp_valid` is high and `rsp_ready` is low, `rsp_code` and `rsp_paddr` hold their values.
- R10: After reset:
  - `req_ready` is high;
  - `busy`, `rsp_valid` and `mem_req` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| seg_wr_en | input | 1 | Segment register write strobe |
| seg_wr_idx | input | 3 | Segment entry to write |
| seg_wr_base | input | 32 | Page table byte address |
| seg_wr_bound | input | 18 | Number of page table entries |
| req_valid | input | 1 | Virtual address offered |
| req_ready | output | 1 | Translator can accept an address |
| req_vaddr | input | 32 | Virtual address |
| mem_req | output | 1 | One-cycle page table read request |
| mem_addr | output | 32 | Page table entry byte address |
| mem_rvalid | input | 1 | Read data returned |
| mem_rdata | input | 32 | Page table entry |
| rsp_valid | output | 1 | Result available |
| rsp_ready | input | 1 | Consumer takes the result |
| rsp_code | output | 2 | 0 ok, 1 segment fault, 2 bound fault, 3 page fault |
| rsp_paddr | output | 30 | Physical address (0 on any fault) |
| busy | output | 1 | A translation is in progress |

## Verification
The failures that matter here show up in the result of the translation that caused them. A stale segment entry or a wrong comparison edge shows up as a wrong `rsp_code` on that same result. A misformed entry address shows up there too: the read returns an empty entry and the code reads page fault. Checking results at the bound minus one and at the bound separates an off-by-one limit from a correct one. A count of memory requests, compared with the number of in-range requests, exposes any read issued for a faulting access. Holding `rsp_ready` low for several cycles exposes a result register that changes while it waits to be taken.

// File: rtl/segpage_pkg.sv
package segpage_pkg;
  typedef enum logic [1:0] {
    XL_OK          = 2'd0,
    XL_SEG_FAULT   = 2'd1,
    XL_BOUND_FAULT = 2'd2,
    XL_PAGE_FAULT  = 2'd3
  } xl_code_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_MEM  = 2'd1,
    ST_WAIT = 2'd2,
    ST_RESP = 2'd3
  } xl_state_e;
endpackage

// File: rtl/segpage_seg_regs.sv
module segpage_seg_regs #(
  parameter int SEG_W     = 3,
  parameter int SEG_COUNT = 6,
  parameter int AW        = 32,
  parameter int BND_W     = 18
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [SEG_W-1:0] wr_idx,
  input  logic [AW-1:0]    wr_base,
  input  logic [BND_W-1:0] wr_bound,
  input  logic [SEG_W-1:0] rd_idx,
  output logic [AW-1:0]    rd_base,
  output logic [BND_W-1:0] rd_bound,
  output logic             rd_present
);
  localparam int SLOTS = 1 << SEG_W;

  logic [AW-1:0]    base_arr  [SLOTS];
  logic [BND_W-1:0] bound_arr [SLOTS];

  for (genvar i = 0; i < SLOTS; i++) begin : g_slot
    if (i < SEG_COUNT) begin : g_impl
      logic [AW-1:0]    base_q;
      logic [BND_W-1:0] bound_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          base_q  <= '0;
          bound_q <= '0;
        end else if (wr_en && wr_idx == SEG_W'(i)) begin
          base_q  <= wr_base;
          bound_q <= wr_bound;
        end
      end
      assign base_arr[i]  = base_q;
      assign bound_arr[i] = bound_q;
    end else begin : g_absent
      assign base_arr[i]  = '0;
      assign bound_arr[i] = '0;
    end
  end

  assign rd_base    = base_arr[rd_idx];
  assign rd_bound   = bound_arr[rd_idx];
  assign rd_present = (32'(rd_idx) < SEG_COUNT);
endmodule

// File: rtl/segpage_check.sv
module segpage_check
  import segpage_pkg::*;
#(
  parameter int VPN_W = 17,
  parameter int AW    = 32,
  parameter int BND_W = 18,
  parameter int PTE_SHIFT = 2
) (
  input  logic             present,
  input  logic [VPN_W-1:0] vpn,
  input  logic [AW-1:0]    base,
  input  logic [BND_W-1:0] bound,
  output xl_code_e         code,
  output logic [AW-1:0]    pte_addr
);
  logic in_range;

  assign in_range = (BND_W'(vpn) < bound);
  assign pte_addr = base + (AW'(vpn) << PTE_SHIFT);

  always_comb begin
    if (!present)       code = XL_SEG_FAULT;
    else if (!in_range) code = XL_BOUND_FAULT;
    else                code = XL_OK;
  end
endmodule

// File: rtl/segpage_xlate.sv
module segpage_xlate
  import segpage_pkg::*;
#(
  parameter int SEG_W     = 3,
  parameter int VPN_W     = 17,
  parameter int OFF_W     = 12,
  parameter int PPN_W     = 18,
  parameter int SEG_COUNT = 6,
  parameter int AW        = 32,
  parameter int DW        = 32,
  localparam int VA_W     = SEG_W + VPN_W + OFF_W,
  localparam int PA_W     = PPN_W + OFF_W,
  localparam int BND_W    = VPN_W + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             seg_wr_en,
  input  logic [SEG_W-1:0] seg_wr_idx,
  input  logic [AW-1:0]    seg_wr_base,
  input  logic [BND_W-1:0] seg_wr_bound,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic [VA_W-1:0]  req_vaddr,
  output logic             mem_req,
  output logic [AW-1:0]    mem_addr,
  input  logic             mem_rvalid,
  input  logic [DW-1:0]    mem_rdata,
  output logic             rsp_valid,
  input  logic             rsp_ready,
  output logic [1:0]       rsp_code,
  output logic [PA_W-1:0]  rsp_paddr,
  output logic             busy
);
  localparam int PTE_SHIFT = $clog2(DW / 8);
  localparam int VLD_BIT   = DW - 1;

  xl_state_e state_q;
  logic [SEG_W-1:0] va_seg;
  logic [VPN_W-1:0] va_vpn;
  logic [OFF_W-1:0] va_off;
  logic [AW-1:0]    sel_base;
  logic [BND_W-1:0] sel_bound;
  logic             sel_present;
  xl_code_e         chk_code;
  logic [AW-1:0]    chk_addr;

  logic [OFF_W-1:0] off_q;
  logic [AW-1:0]    pte_addr_q;
  xl_code_e         code_q;
  logic [PA_W-1:0]  paddr_q;
  logic             unused_rdata;

  assign va_seg = req_vaddr[VA_W-1 -: SEG_W];
  assign va_vpn = req_vaddr[OFF_W +: VPN_W];
  assign va_off = req_vaddr[OFF_W-1:0];
  assign unused_rdata = ^mem_rdata[VLD_BIT-1:PPN_W];

  segpage_seg_regs #(
    .SEG_W(SEG_W), .SEG_COUNT(SEG_COUNT), .AW(AW), .BND_W(BND_W)
  ) u_regs (
    .clk(clk), .rst_n(rst_n),
    .wr_en(seg_wr_en), .wr_idx(seg_wr_idx),
    .wr_base(seg_wr_base), .wr_bound(seg_wr_bound),
    .rd_idx(va_seg), .rd_base(sel_base), .rd_bound(sel_bound),
    .rd_present(sel_present)
  );

  segpage_check #(
    .VPN_W(VPN_W), .AW(AW), .BND_W(BND_W), .PTE_SHIFT(PTE_SHIFT)
  ) u_check (
    .present(sel_present), .vpn(va_vpn), .base(sel_base),
    .bound(sel_bound), .code(chk_code), .pte_addr(chk_addr)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q    <= ST_IDLE;
      off_q      <= '0;
      pte_addr_q <= '0;
      code_q     <= XL_OK;
      paddr_q    <= '0;
    end else begin
      unique case (state_q)
        ST_IDLE: if (req_valid) begin
          off_q      <= va_off;
          pte_addr_q <= chk_addr;
          if (chk_code != XL_OK) begin
            code_q  <= chk_code;
            paddr_q <= '0;
            state_q <= ST_RESP;
          end else begin
            state_q <= ST_MEM;
          end
        end
        ST_MEM: state_q <= ST_WAIT;
        ST_WAIT: if (mem_rvalid) begin
          if (mem_rdata[VLD_BIT]) begin
            code_q  <= XL_OK;
            paddr_q <= {mem_rdata[PPN_W-1:0], off_q};
          end else begin
            code_q  <= XL_PAGE_FAULT;
            paddr_q <= '0;
          end
          state_q <= ST_RESP;
        end
        ST_RESP: if (rsp_ready) state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign req_ready = (state_q == ST_IDLE);
  assign mem_req   = (state_q == ST_MEM);
  assign mem_addr  = pte_addr_q;
  assign rsp_valid = (state_q == ST_RESP);
  assign rsp_code  = code_q;
  assign rsp_paddr = paddr_q;
  assign busy      = (state_q != ST_IDLE);
endmodule

// File: rtl/segpage_xlate_props.sv
module segpage_xlate_props #(
  parameter int PA_W = 30
) (
  input logic            clk,
  input logic            rst_n,
  input logic            req_valid,
  input logic            req_ready,
  input logic            busy,
  input logic            mem_req,
  input logic            rsp_valid,
  input logic            rsp_ready,
  input logic [1:0]      rsp_code,
  input logic [PA_W-1:0] rsp_paddr
);
  assert_accept_busy_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> (busy && !req_ready));

  assert_read_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |=> !mem_req);

  assert_read_only_busy_R5: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> (busy && !rsp_valid));

  assert_no_read_on_fault_R3_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(rsp_valid) && (rsp_code == 2'd1 || rsp_code == 2'd2)) |-> !$past(mem_req));

  assert_fault_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_code != 2'd0) |-> (rsp_paddr == '0));

  assert_hold_result_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_code) && $stable(rsp_paddr)));
endmodule

bind segpage_xlate segpage_xlate_props #(.PA_W(PA_W)) u_props (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .busy(busy), .mem_req(mem_req), .rsp_valid(rsp_valid), .rsp_ready(rsp_ready),
  .rsp_code(rsp_code), .rsp_paddr(rsp_paddr)
);

// File: tb/segpage_xlate_test.sv
module segpage_xlate_test;
  logic        clk = 0;
  logic        rst_n = 0;
  logic        seg_wr_en = 0;
  logic [2:0]  seg_wr_idx = '0;
  logic [31:0] seg_wr_base = '0;
  logic [17:0] seg_wr_bound = '0;
  logic        req_valid = 0;
  logic        req_ready;
  logic [31:0] req_vaddr = '0;
  logic        mem_req;
  logic [31:0] mem_addr;
  logic        mem_rvalid = 0;
  logic [31:0] mem_rdata = '0;
  logic        rsp_valid;
  logic        rsp_ready = 1;
  logic [1:0]  rsp_code;
  logic [29:0] rsp_paddr;
  logic        busy;

  always #4 clk = ~clk;

  segpage_xlate uut (
    .clk(clk), .rst_n(rst_n),
    .seg_wr_en(seg_wr_en), .seg_wr_idx(seg_wr_idx),
    .seg_wr_base(seg_wr_base), .seg_wr_bound(seg_wr_bound),
    .req_valid(req_valid), .req_ready(req_ready), .req_vaddr(req_vaddr),
    .mem_req(mem_req), .mem_addr(mem_addr),
    .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready),
    .rsp_code(rsp_code), .rsp_paddr(rsp_paddr), .busy(busy)
  );

  int total = 0;
  int bad = 0;
  bit finished = 0;
  int reads_seen = 0;
  int reads_expected = 0;
  bit bp_mode = 0;
  int cyc = 0;

  logic [31:0] ref_base [8];
  logic [17:0] ref_bound [8];
  logic [31:0] pt_mem [logic [31:0]];

  logic [31:0] exp_q [$];
  string       tag_q [$];

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic write_seg(input int idx, input logic [31:0] b, input logic [17:0] n);
    @(negedge clk);
    seg_wr_en = 1; seg_wr_idx = 3'(idx); seg_wr_base = b; seg_wr_bound = n;
    if (idx < 6) begin ref_base[idx] = b; ref_bound[idx] = n; end
    @(negedge clk);
    seg_wr_en = 0;
  endtask

  task automatic send(input logic [31:0] va, input string tag);
    logic [2:0]  s;
    logic [16:0] vpn;
    logic [11:0] off;
    logic [31:0] pte;
    logic [31:0] ad;
    logic [1:0]  code;
    logic [29:0] pa;
    s = va[31:29]; vpn = va[28:12]; off = va[11:0];
    pa = '0;
    if (s >= 3'd6) code = 2'd1;
    else if ({1'b0, vpn} >= ref_bound[s]) code = 2'd2;
    else begin
      ad = ref_base[s] + {13'd0, vpn, 2'b00};
      pte = pt_mem.exists(ad) ? pt_mem[ad] : 32'd0;
      reads_expected++;
      if (pte[31]) begin code = 2'd0; pa = {pte[17:0], off}; end
      else code = 2'd3;
    end
    exp_q.push_back({code, pa});
    tag_q.push_back(tag);
    @(negedge clk);
    req_valid = 1; req_vaddr = va;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 0;
    check(busy && !req_ready, "R8", {30'd0, busy, req_ready}, 32'h2);
  endtask

  task automatic drain;
    while (exp_q.size() != 0 || busy) @(negedge clk);
  endtask

  // memory model with rotating latency
  initial begin
    bit pend = 0;
    int wait_cnt = 0;
    int lat_sel = 0;
    logic [31:0] ad = '0;
    forever begin
      @(negedge clk);
      mem_rvalid = 0;
      if (pend) begin
        if (wait_cnt == 0) begin
          mem_rvalid = 1;
          mem_rdata = pt_mem.exists(ad) ? pt_mem[ad] : 32'd0;
          pend = 0;
        end else wait_cnt--;
      end
      if (mem_req) begin
        pend = 1; ad = mem_addr; wait_cnt = lat_sel;
        lat_sel = (lat_sel + 1) % 4;
        reads_seen++;
      end
    end
  end

  // response ready driver and scoreboard monitor
  initial begin
    forever begin
      @(negedge clk);
      cyc++;
      rsp_ready = bp_mode ? (cyc % 4 == 0) : 1'b1;
      if (rsp_valid && rsp_ready) begin
        if (exp_q.size() == 0) begin
          check(0, "R8", {rsp_code, rsp_paddr}, 32'hx);
        end else begin
          logic [31:0] e;
          string t;
          e = exp_q.pop_front();
          t = tag_q.pop_front();
          check({rsp_code, rsp_paddr} === e, t, {rsp_code, rsp_paddr}, e);
        end
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      bad++; total++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 8; i++) begin ref_base[i] = '0; ref_bound[i] = '0; end
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R10: reset state
    check(req_ready && !busy && !rsp_valid && !mem_req, "R10",
          {28'd0, req_ready, busy, rsp_valid, mem_req}, 32'h8);

    // R2: reset bound is 0, so every page of segment 0 faults
    send(32'h0000_0000, "R2 reset bound");
    drain();

    pt_mem[32'h0010_0000 + 3*4] = 32'h8002_ABCD;
    pt_mem[32'h0010_0000 + 7*4] = 32'h8003_FFFF;
    pt_mem[32'h0010_0000 + 0*4] = 32'h8000_0001;
    pt_mem[32'h0020_0000 + 32'h1FFFF*4] = 32'h8001_2345;
    pt_mem[32'h0030_0000 + 5*4] = 32'h0003_FFFF;
    write_seg(0, 32'h0010_0000, 18'd8);
    write_seg(1, 32'h0020_0000, 18'h20000);
    write_seg(2, 32'h0040_0000, 18'd0);
    write_seg(3, 32'h0030_0000, 18'd16);

    send({3'd0, 17'd3, 12'h123}, "R7 R1 valid entry");
    send({3'd0, 17'd7, 12'hFFF}, "R7 R4 last page below bound");
    send({3'd0, 17'd8, 12'h000}, "R4 page equal to bound");
    send({3'd0, 17'h1FFFF, 12'h001}, "R4 page far above bound");
    send({3'd2, 17'd0, 12'h055}, "R4 zero bound");
    send({3'd6, 17'd0, 12'h000}, "R3 segment 6");
    send({3'd7, 17'd1, 12'h0AB}, "R3 segment 7");
    send({3'd3, 17'd5, 12'h777}, "R6 cleared valid bit");
    send({3'd3, 17'd6, 12'h777}, "R6 missing entry");
    send({3'd1, 17'h1FFFF, 12'hABC}, "R5 R7 top page of full table");
    send({3'd0, 17'd0, 12'h800}, "R1 R5 page zero");
    drain();

    // R9: back-pressure on results
    bp_mode = 1;
    send({3'd0, 17'd3, 12'h456}, "R9 held valid result");
    send({3'd6, 17'd2, 12'h000}, "R9 held fault result");
    send({3'd1, 17'h1FFFF, 12'h010}, "R9 held after wait");
    drain();
    bp_mode = 0;

    // R2: rewrite shrinks the segment
    write_seg(0, 32'h0010_0000, 18'd3);
    send({3'd0, 17'd3, 12'h123}, "R2 rewritten bound");
    send({3'd0, 17'd0, 12'h321}, "R2 rewritten still valid");
    drain();

    repeat (4) @(negedge clk);
    // R3 R4 R5: reads issued only for in-range accesses
    check(reads_seen == reads_expected, "R5 read count",
          32'(reads_seen), 32'(reads_expected));
    check(!busy && req_ready && !mem_req, "R8 idle at end",
          {29'd0, busy, req_ready, mem_req}, 32'h2);

    if (!finished) begin
      finished = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule